// File: doc/BRIEF.md
# Core Power, Clock and Reset Sequencer

This controller takes one processor core power domain from fully unpowered to running, and later returns it to a clock-gated, warm-reset state with power kept on. It drives the power-switch enable, the clock-divider alignment reset, the core clock-enable request, the power-on reset, the isolation enable, the module warm reset and the clock-stop request. It paces itself on three acknowledge inputs: power good, clock-enable acknowledge and clock-stop acknowledge.

A one-cycle start pulse in the unpowered state runs the whole power-up and enable sequence. A stop pulse while running begins shutdown, which waits for the core to report idle. A later start pulse from the gated state repeats only the enable phase. Every acknowledge wait is bounded by a timeout. A missed acknowledge freezes the control outputs and raises an error flag until the controller's own reset.

Reset, isolation, warm reset and clock-stop outputs are active high. All waits are parameters: `PULSE_CYCLES`, `POR_SETTLE_CYCLES`, `WARM_RST_DELAY` and `TIMEOUT_CYCLES`. Each must be at least 1.

Top module: `core_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs hold the unpowered values: `pwr_sw_en`=0, `divalign_rst`=0, `clk_en`=0, `por_rst`=1, `iso_en`=1, `warm_rst`=1, `clkstop_req`=1, `running`=0, `busy`=0, `error`=0.
- R2: A start pulse in the unpowered state raises `pwr_sw_en` first. At that point `clk_en` and `divalign_rst` are low and both resets and isolation are still asserted. The controller then waits for `pwr_good`.
- R3: Once `pwr_good` is seen, `divalign_rst` is high for exactly `PULSE_CYCLES` cycles, and `clk_en` stays low while it is high.
- R4: After the alignment reset, `clk_en` is high for at least `PULSE_CYCLES` cycles and until `clken_ack` is seen. It is then dropped while `por_rst` and `warm_rst` are still high, and the controller waits for `clken_ack` to fall.
- R5: `por_rst` is released next. `iso_en` falls exactly `POR_SETTLE_CYCLES` cycles later.
- R6: `warm_rst` falls `WARM_RST_DELAY` cycles after isolation is released. `clk_en` then rises. After `clken_ack`, `clkstop_req` falls. After `clkstop_ack` falls, the controller is running.
- R7: A stop pulse while running waits for `core_idle` before it raises `clkstop_req`. After `clkstop_ack`, it drops `clk_en`. After `clken_ack` falls, it asserts `warm_rst` and enters the gated state. Power stays on, and `por_rst` and `iso_en` stay released.
- R8: A start pulse in the gated state repeats the enable phase of R6 without changing `pwr_sw_en`, `por_rst` or `iso_en`.
- R9: If an awaited acknowledge does not arrive within `TIMEOUT_CYCLES` cycles of entering the wait, `error` rises and the seven control outputs keep their values until `rst_n` is asserted.
- R10: `running` is high only in the running state. `busy` is high in every transition state, including the wait for core idle, and low when unpowered, running, gated or in error.
- R11: Start and stop pulses have no effect in any state except two: start is accepted when unpowered or gated, and stop is accepted when running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| start_req | input | 1 | Start command pulse |
| stop_req | input | 1 | Stop command pulse |
| core_idle | input | 1 | Core reports it has entered idle |
| pwr_good | input | 1 | Power switch reports the rail is up |
| clken_ack | input | 1 | Acknowledge that follows `clk_en` |
| clkstop_ack | input | 1 | Acknowledge that follows `clkstop_req` |
| pwr_sw_en | output | 1 | Power-switch enable |
| divalign_rst | output | 1 | Clock-divider alignment reset |
| clk_en | output | 1 | Core clock-enable request |
| por_rst | output | 1 | Power-on reset to the core |
| iso_en | output | 1 | Isolation enable |
| warm_rst | output | 1 | Module warm reset |
| clkstop_req | output | 1 | Clock-stop request |
| running | output | 1 | Core is in the running state |
| busy | output | 1 | A sequence is in progress |
| error | output | 1 | An acknowledge timed out |

## Verification
The assertions check every cycle the ordering rules that hold in any run. Power comes on with clocks off. The clock enable stays low during the alignment reset. Isolation is released only once power-on reset is out. The clock-stop request never rises without idle having been seen. The warm reset is applied only with clocks gated. The error state sticks, frozen outputs stay still, and the countdown never wraps. Only the bench scenarios can show the exact durations of the fixed waits, the complete order of output changes through power-up, shutdown and re-enable, that commands outside their accepted states change nothing, and the exact timeout distance.

// File: rtl/core_pwr_seq_pkg.sv
// Package for the core power sequencer: state encoding, control-output
// bundle and the per-state output decode shared by the FSM and output stage.
package core_pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF, ST_PWR_UP, ST_DIV_RST, ST_PULSE_ON, ST_PULSE_ACK,
        ST_PULSE_OFF, ST_POR_SETTLE, ST_WARM_WAIT, ST_EN_CLK, ST_EN_CSTOP,
        ST_RUN, ST_STOP_IDLE, ST_STOP_CSTOP, ST_STOP_CLK, ST_GATED, ST_ERR
    } cps_state_e;

    typedef struct packed {
        logic pwr_sw_en;
        logic div_rst;
        logic clk_en;
        logic por_rst;
        logic iso_en;
        logic warm_rst;
        logic clkstop_req;
    } cps_ctl_t;

    // Control-output values for each state; ERR is never decoded (outputs freeze).
    function automatic cps_ctl_t cps_decode(cps_state_e s);
        cps_ctl_t c;
        c = '{pwr_sw_en: 1'b0, div_rst: 1'b0, clk_en: 1'b0, por_rst: 1'b1,
              iso_en: 1'b1, warm_rst: 1'b1, clkstop_req: 1'b1};
        case (s)
            ST_OFF:        ;
            ST_PWR_UP:     c.pwr_sw_en = 1'b1;
            ST_DIV_RST:    begin c.pwr_sw_en = 1'b1; c.div_rst = 1'b1; end
            ST_PULSE_ON,
            ST_PULSE_ACK:  begin c.pwr_sw_en = 1'b1; c.clk_en = 1'b1; end
            ST_PULSE_OFF:  c.pwr_sw_en = 1'b1;
            ST_POR_SETTLE: begin c.pwr_sw_en = 1'b1; c.por_rst = 1'b0; end
            ST_WARM_WAIT,
            ST_GATED:      begin c.pwr_sw_en = 1'b1; c.por_rst = 1'b0; c.iso_en = 1'b0; end
            ST_EN_CLK,
            ST_STOP_CSTOP: begin
                c.pwr_sw_en = 1'b1; c.por_rst = 1'b0; c.iso_en = 1'b0;
                c.warm_rst = 1'b0; c.clk_en = 1'b1;
            end
            ST_EN_CSTOP,
            ST_RUN,
            ST_STOP_IDLE:  begin
                c.pwr_sw_en = 1'b1; c.por_rst = 1'b0; c.iso_en = 1'b0;
                c.warm_rst = 1'b0; c.clk_en = 1'b1; c.clkstop_req = 1'b0;
            end
            ST_STOP_CLK:   begin
                c.pwr_sw_en = 1'b1; c.por_rst = 1'b0; c.iso_en = 1'b0;
                c.warm_rst = 1'b0;
            end
            default:       ;
        endcase
        return c;
    endfunction

    // Transition states report busy; resting states and ERR do not.
    function automatic logic cps_is_busy(cps_state_e s);
        return !(s inside {ST_OFF, ST_RUN, ST_GATED, ST_ERR});
    endfunction

endpackage

// File: rtl/cps_timer.sv
// Shared countdown for fixed waits and acknowledge timeouts.
// Assumes: load is pulsed on every state entry with (cycles - 1); zero
// therefore goes high in the last cycle of the window and stays high.
module cps_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load on entry, otherwise count down and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R9: the timeout window never wraps once it has expired.
    p_cnt_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

    // R9: without a reload the window shrinks by exactly one per cycle.
    p_cnt_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cps_fsm.sv
// Sequencing state machine: fixed power-up, enable and shutdown order,
// command filtering and acknowledge timeouts.
// Assumes: start_req/stop_req are synchronous pulses; acknowledges are
// synchronous to clk.
module cps_fsm
    import core_pwr_seq_pkg::*;
#(
    parameter int PULSE_CYCLES      = 4,
    parameter int POR_SETTLE_CYCLES = 8,
    parameter int WARM_RST_DELAY    = 4,
    parameter int TIMEOUT_CYCLES    = 64,
    parameter int CNT_W             = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             core_idle,
    input  logic             pwr_good,
    input  logic             clken_ack,
    input  logic             clkstop_ack,
    input  logic             tmr_zero,
    output cps_state_e       state_d,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] PulseLd = CNT_W'(PULSE_CYCLES - 1);
    localparam logic [CNT_W-1:0] PorLd   = CNT_W'(POR_SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] WarmLd  = CNT_W'(WARM_RST_DELAY - 1);
    localparam logic [CNT_W-1:0] ToutLd  = CNT_W'(TIMEOUT_CYCLES - 1);

    cps_state_e state_q;

    // State register; ERR is left only through rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next-state: fixed order, acknowledge waits fall to ERR on timeout.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:        if (start_req)    state_d = ST_PWR_UP;
            ST_PWR_UP:     if (pwr_good)     state_d = ST_DIV_RST;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_DIV_RST:    if (tmr_zero)     state_d = ST_PULSE_ON;
            ST_PULSE_ON:   if (tmr_zero)     state_d = ST_PULSE_ACK;
            ST_PULSE_ACK:  if (clken_ack)    state_d = ST_PULSE_OFF;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_PULSE_OFF:  if (!clken_ack)   state_d = ST_POR_SETTLE;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_POR_SETTLE: if (tmr_zero)     state_d = ST_WARM_WAIT;
            ST_WARM_WAIT:  if (tmr_zero)     state_d = ST_EN_CLK;
            ST_EN_CLK:     if (clken_ack)    state_d = ST_EN_CSTOP;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_EN_CSTOP:   if (!clkstop_ack) state_d = ST_RUN;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_RUN:        if (stop_req)     state_d = ST_STOP_IDLE;
            ST_STOP_IDLE:  if (core_idle)    state_d = ST_STOP_CSTOP;
            ST_STOP_CSTOP: if (clkstop_ack)  state_d = ST_STOP_CLK;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_STOP_CLK:   if (!clken_ack)   state_d = ST_GATED;
                           else if (tmr_zero) state_d = ST_ERR;
            ST_GATED:      if (start_req)    state_d = ST_WARM_WAIT;
            default:                         state_d = ST_ERR;
        endcase
    end

    // Timer reload on each state entry with that state's window.
    always_comb begin
        tmr_load = (state_d != state_q);
        case (state_d)
            ST_DIV_RST, ST_PULSE_ON: tmr_val = PulseLd;
            ST_POR_SETTLE:           tmr_val = PorLd;
            ST_WARM_WAIT:            tmr_val = WarmLd;
            ST_PWR_UP, ST_PULSE_ACK, ST_PULSE_OFF, ST_EN_CLK,
            ST_EN_CSTOP, ST_STOP_CSTOP, ST_STOP_CLK: tmr_val = ToutLd;
            default:                 tmr_val = '0;
        endcase
    end

    // R9: the error state is held until reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR) |=> (state_q == ST_ERR));

    // R7: the clock-stop phase is entered only from the idle wait with idle seen.
    p_cstop_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP_CSTOP && $past(state_q) != ST_STOP_CSTOP)
            |-> ($past(state_q) == ST_STOP_IDLE && $past(core_idle)));

endmodule

// File: rtl/cps_outreg.sv
// Registered output stage: control outputs and status flags follow the
// next state so they change on the same edge as the state register.
// Assumes: on entry to ERR the control outputs keep their last values.
module cps_outreg
    import core_pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cps_state_e state_d,
    output cps_ctl_t   ctl,
    output logic       running,
    output logic       busy,
    output logic       error
);

    // Output register; control bundle frozen while heading into ERR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= cps_decode(ST_OFF);
            running <= 1'b0;
            busy    <= 1'b0;
            error   <= 1'b0;
        end else begin
            if (state_d != ST_ERR) ctl <= cps_decode(state_d);
            running <= (state_d == ST_RUN);
            busy    <= cps_is_busy(state_d);
            error   <= (state_d == ST_ERR);
        end
    end

    // R9: control outputs stay still for as long as the error flag stays up.
    p_err_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (error && $past(error)) |-> $stable(ctl));

    // R10: running excludes busy and error.
    p_run_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (!busy && !error));

endmodule

// File: rtl/core_pwr_seq.sv
// Top of the core power, clock and reset sequencer.
// Assumes: one clock domain; all wait parameters >= 1; acknowledge inputs
// already synchronised to clk.
module core_pwr_seq
    import core_pwr_seq_pkg::*;
#(
    parameter int PULSE_CYCLES      = 4,
    parameter int POR_SETTLE_CYCLES = 8,
    parameter int WARM_RST_DELAY    = 4,
    parameter int TIMEOUT_CYCLES    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic core_idle,
    input  logic pwr_good,
    input  logic clken_ack,
    input  logic clkstop_ack,
    output logic pwr_sw_en,
    output logic divalign_rst,
    output logic clk_en,
    output logic por_rst,
    output logic iso_en,
    output logic warm_rst,
    output logic clkstop_req,
    output logic running,
    output logic busy,
    output logic error
);

    localparam int MaxA  = (PULSE_CYCLES > POR_SETTLE_CYCLES) ? PULSE_CYCLES : POR_SETTLE_CYCLES;
    localparam int MaxB  = (WARM_RST_DELAY > TIMEOUT_CYCLES) ? WARM_RST_DELAY : TIMEOUT_CYCLES;
    localparam int MaxV  = (MaxA > MaxB) ? MaxA : MaxB;
    localparam int CNT_W = (MaxV < 2) ? 1 : $clog2(MaxV);

    cps_state_e       state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    cps_ctl_t         ctl;

    cps_fsm #(
        .PULSE_CYCLES      (PULSE_CYCLES),
        .POR_SETTLE_CYCLES (POR_SETTLE_CYCLES),
        .WARM_RST_DELAY    (WARM_RST_DELAY),
        .TIMEOUT_CYCLES    (TIMEOUT_CYCLES),
        .CNT_W             (CNT_W)
    ) u_fsm (
        .clk, .rst_n, .start_req, .stop_req, .core_idle, .pwr_good,
        .clken_ack, .clkstop_ack, .tmr_zero, .state_d, .tmr_load, .tmr_val
    );

    cps_timer #(.W(CNT_W)) u_timer (
        .clk, .rst_n, .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    cps_outreg u_out (
        .clk, .rst_n, .state_d, .ctl, .running, .busy, .error
    );

    assign pwr_sw_en    = ctl.pwr_sw_en;
    assign divalign_rst = ctl.div_rst;
    assign clk_en       = ctl.clk_en;
    assign por_rst      = ctl.por_rst;
    assign iso_en       = ctl.iso_en;
    assign warm_rst     = ctl.warm_rst;
    assign clkstop_req  = ctl.clkstop_req;

    // R2: power comes on with clocks off and the core held in reset.
    p_pwr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_sw_en) |-> (!clk_en && !divalign_rst && por_rst && iso_en && warm_rst));

    // R3: no clock enable during the alignment reset.
    p_no_clk_in_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        divalign_rst |-> !clk_en);

    // R5: isolation drops only after power-on reset has been out.
    p_iso_after_por_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_en) |-> (!por_rst && $past(!por_rst)));

    // R7: clock-stop request rises only after idle has been reported.
    p_cstop_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkstop_req) |-> $past(core_idle));

    // R7: warm reset is applied only with clocks gated and stopped.
    p_warm_when_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_rst) |-> (!clk_en && clkstop_req));

endmodule

// File: tb/core_pwr_seq_tb.sv
`timescale 1ns/1ps
module core_pwr_seq_tb;

    localparam int PULSE = 3;
    localparam int PORN  = 5;
    localparam int WARM  = 4;
    localparam int TOUT  = 8;

    // Vector bit order: pwr div clk_en por iso warm cstop running busy error
    localparam logic [9:0] V_OFF   = 10'b0001111000;
    localparam logic [9:0] V_PWRUP = 10'b1001111010;
    localparam logic [9:0] V_DIV   = 10'b1101111010;
    localparam logic [9:0] V_PULSE = 10'b1011111010;
    localparam logic [9:0] V_POR   = 10'b1000111010;
    localparam logic [9:0] V_WARM  = 10'b1000011010;
    localparam logic [9:0] V_ENCLK = 10'b1010001010;
    localparam logic [9:0] V_ENCS  = 10'b1010000010;
    localparam logic [9:0] V_RUN   = 10'b1010000100;
    localparam logic [9:0] V_STCLK = 10'b1000001010;
    localparam logic [9:0] V_GATED = 10'b1000011000;
    localparam logic [9:0] V_ERR   = 10'b1001111001;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0, core_idle = 1'b0;
    logic pwr_good, clken_ack, clkstop_ack;
    logic pwr_sw_en, divalign_rst, clk_en, por_rst, iso_en, warm_rst;
    logic clkstop_req, running, busy, error;
    logic pg_en = 1'b1;
    logic pg_d, ce_d, cs_d;

    int checks = 0, failures = 0, cyc = 0, t_last = 0;
    bit mon_en = 0, started = 0, have_pend = 0;
    logic [9:0] prev;

    typedef struct {
        logic [9:0] vec;
        int         mn;
        int         mx;
        string      req;
    } exp_t;
    exp_t q[$];
    exp_t pend;

    core_pwr_seq #(.PULSE_CYCLES(PULSE), .POR_SETTLE_CYCLES(PORN),
                   .WARM_RST_DELAY(WARM), .TIMEOUT_CYCLES(TOUT)) u_dut (
        .clk, .rst_n, .start_req, .stop_req, .core_idle, .pwr_good,
        .clken_ack, .clkstop_ack, .pwr_sw_en, .divalign_rst, .clk_en,
        .por_rst, .iso_en, .warm_rst, .clkstop_req, .running, .busy, .error
    );

    always #2.5 clk = ~clk;

    // Acknowledge models: each follows its request two cycles later.
    always @(posedge clk) begin
        pg_d        <= pwr_sw_en & pg_en;
        pwr_good    <= pg_d;
        ce_d        <= clk_en;
        clken_ack   <= ce_d;
        cs_d        <= clkstop_req;
        clkstop_ack <= cs_d;
    end

    function automatic logic [9:0] vec_now();
        return {pwr_sw_en, divalign_rst, clk_en, por_rst, iso_en, warm_rst,
                clkstop_req, running, busy, error};
    endfunction

    task automatic push(logic [9:0] v, int mn, int mx, string req);
        exp_t e;
        e.vec = v; e.mn = mn; e.mx = mx; e.req = req;
        q.push_back(e);
    endtask

    task automatic check(bit ok, string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse_cmd(bit st, bit sp);
        @(negedge clk);
        start_req = st; stop_req = sp;
        @(negedge clk);
        start_req = 1'b0; stop_req = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_running();
        for (int i = 0; i < 300 && !running; i++) @(negedge clk);
    endtask

    // Monitor: on each output change, check the previous hold time and pop the next expected vector.
    always @(negedge clk) begin
        if (mon_en) begin
            logic [9:0] cur;
            cyc++;
            cur = vec_now();
            if (!started) begin
                prev = cur; started = 1; t_last = cyc;
            end else if (cur !== prev) begin
                if (have_pend && pend.mn >= 0) begin
                    checks++;
                    if ((cyc - t_last) < pend.mn || (cyc - t_last) > pend.mx) begin
                        failures++;
                        $display("FAIL %s hold of %b actual=%0d expected=%0d..%0d",
                                 pend.req, prev, cyc - t_last, pend.mn, pend.mx);
                    end
                end
                checks++;
                if (q.size() == 0) begin
                    failures++;
                    $display("FAIL R11 unexpected change actual=%b expected=%b", cur, prev);
                    have_pend = 0;
                end else begin
                    pend = q.pop_front();
                    have_pend = 1;
                    if (cur !== pend.vec) begin
                        failures++;
                        $display("FAIL %s actual=%b expected=%b", pend.req, cur, pend.vec);
                    end
                end
                t_last = cyc;
                prev = cur;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Driver: queue the expected output sequence, then apply commands.
    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        check(vec_now() === V_OFF, "R1 reset state", vec_now(), V_OFF);
        mon_en = 1;

        // R11: stop while unpowered is ignored.
        pulse_cmd(0, 1);
        wait_cycles(5);
        check(vec_now() === V_OFF, "R11 stop in off", vec_now(), V_OFF);

        // R2..R6: full power-up; the fixed waits must be exact.
        push(V_PWRUP, 1, TOUT, "R2 power switch first");
        push(V_DIV, PULSE, PULSE, "R3 alignment reset");
        push(V_PULSE, PULSE, PULSE + TOUT, "R4 reset clock pulse");
        push(V_PWRUP, 1, TOUT, "R4 pulse dropped in reset");
        push(V_POR, PORN, PORN, "R5 por to isolation");
        push(V_WARM, WARM, WARM, "R6 warm reset delay");
        push(V_ENCLK, 1, TOUT, "R6 clock enable");
        push(V_ENCS, 1, TOUT, "R6 clock stop released");
        push(V_RUN, -1, -1, "R10 running");
        pulse_cmd(1, 0);
        pulse_cmd(1, 1);   // R11: commands during the transition are ignored
        wait_running();
        check(running === 1'b1, "R6 reached running", {9'b0, running}, 10'd1);

        // R11: start while running is ignored.
        pulse_cmd(1, 0);
        wait_cycles(5);
        check(vec_now() === V_RUN, "R11 start in run", vec_now(), V_RUN);

        // R7: shutdown waits for idle, then stop, gate, warm reset.
        push(V_ENCS, 6, 100, "R7 wait for idle");
        push(V_ENCLK, 1, TOUT, "R7 clock stop requested");
        push(V_STCLK, 1, TOUT, "R7 clock gated");
        push(V_GATED, -1, -1, "R7 gated state");
        pulse_cmd(0, 1);
        wait_cycles(6);
        check(clkstop_req === 1'b0, "R7 no stop before idle", {9'b0, clkstop_req}, 10'd0);
        core_idle = 1'b1;
        wait_cycles(20);
        check(vec_now() === V_GATED, "R7 gated outputs", vec_now(), V_GATED);
        core_idle = 1'b0;

        // R11: stop while gated is ignored.
        pulse_cmd(0, 1);
        wait_cycles(5);
        check(vec_now() === V_GATED, "R11 stop in gated", vec_now(), V_GATED);

        // R8: restart from gated repeats only the enable phase.
        push(V_WARM, WARM, WARM, "R8 warm delay on restart");
        push(V_ENCLK, 1, TOUT, "R8 clock enable");
        push(V_ENCS, 1, TOUT, "R8 clock stop released");
        push(V_RUN, -1, -1, "R8 running again");
        pulse_cmd(1, 0);
        wait_running();
        check(running === 1'b1 && por_rst === 1'b0 && iso_en === 1'b0,
              "R8 restart kept power domain", vec_now(), V_RUN);

        // R1: reset returns to unpowered values.
        push(V_OFF, -1, -1, "R1 reset from running");
        @(negedge clk); rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        @(negedge clk);
        check(vec_now() === V_OFF, "R1 after reset", vec_now(), V_OFF);

        // R9: missing power good times out after exactly TOUT cycles and freezes.
        pg_en = 1'b0;
        push(V_PWRUP, TOUT, TOUT, "R9 timeout distance");
        push(V_ERR, -1, -1, "R9 error frozen");
        pulse_cmd(1, 0);
        wait_cycles(20);
        check(vec_now() === V_ERR, "R9 error state", vec_now(), V_ERR);
        pg_en = 1'b1;
        pulse_cmd(1, 0);
        pulse_cmd(0, 1);
        wait_cycles(5);
        check(vec_now() === V_ERR, "R9 error held", vec_now(), V_ERR);
        check(busy === 1'b0 && running === 1'b0, "R10 flags in error", vec_now(), V_ERR);

        push(V_OFF, -1, -1, "R9 cleared by reset");
        @(negedge clk); rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        wait_cycles(3);
        check(q.size() == 0, "R10 all expected changes seen", 10'(q.size()), 10'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule